// File: doc/BRIEF.md
# Six-Channel Attenuation Register Target on a Two-Wire Serial Bus

This block is the control front end of a six-output volume controller. It listens on a two-wire serial bus (I2C, write transfers only), oversamples the clock and data lines with the system clock, and keeps one 8-bit attenuation setting per output channel. A bus master addresses the block, sends a subaddress byte that picks a register slot and a write mode, then streams data bytes. The block acknowledges every byte it takes by pulling the data line low during the ninth clock.

Two write modes exist. In the fixed mode every data byte up to STOP lands in the same slot. In the stepping mode the slot index advances after each byte through an eight-slot ring and wraps back to zero. Slots 6 and 7 are placeholders that take a byte and discard it. Each channel presents its setting as a decoded attenuation in dB (0 to 79) and a mute flag, ready for the analog gain stages.

Top module: `atten_i2c_target`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts address reception from any state. A rising SDA while SCL is high (STOP) returns the block to idle from any state, and a partly received byte is then discarded.
- R2: For each accepted byte, `sda_oe` rises only while SCL is low after the eighth bit. It stays high through the ninth SCL pulse and drops after the following SCL fall.
- R3: The first byte after START is accepted only if it equals 0x88 with `addr_strap` low, or 0x8A with `addr_strap` high. Any other byte, including a read address, is not acknowledged, and the bus is ignored until the next START.
- R4: In the subaddress byte, bits 2..0 pick the slot (0 to 5 are channels 1 to 6; 6 and 7 are placeholders), bit 4 selects stepping mode, and bits 7..5 are ignored. If bit 3 is set, every data byte of the transfer is discarded.
- R5: With subaddress bit 4 clear, every data byte until STOP or START overwrites the one selected channel.
- R6: With subaddress bit 4 set, the first data byte goes to the sent slot. Each later byte goes to the next slot, counting modulo 8. A byte that falls on slot 6 or 7 is discarded but still uses up its place in the sequence.
- R7: Every data byte after an accepted address and subaddress is acknowledged, including bytes that are discarded.
- R8: For a setting byte v, bits 2..0 give a fine step of 0 to 7 dB and bits 7..3 a coarse step of 8 dB each. When not muted, the channel's `ch_atten` field (bits 7c+6..7c for channel c) equals coarse*8+fine, which is at most 79.
- R9: A coarse code of 10 or more (v >= 80) sets the channel's `ch_mute` bit, and its `ch_atten` field then reads 127.
- R10: After reset, all six settings are 0xFF (muted, `ch_atten` fields 127), and `sda_oe` is low.
- R11: Channel outputs change only in the cycle right after the synchronized SCL falls, which ends a data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Address select: low answers 0x88, high answers 0x8A |
| sda_oe | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| ch_atten | output | 42 | Six 7-bit attenuation values in dB, channel 1 in bits 6..0 |
| ch_mute | output | 6 | Per-channel mute flags, channel 1 in bit 0 |

## Verification
Some rules are checked on every cycle by properties: the acknowledge only starts while the sampled clock is low, the block never drives the data line while idle, an unmuted channel never reports more than 79 dB, a muted channel always reports 127, and the outputs stay frozen unless a clock fall has just been seen. The rest depends on what the master sent, so only bench scenarios can show it. That covers address selection by the strap, the fixed and stepping modes with the wrap from slot 7 to slot 0, discarded placeholder and high-subaddress bytes, recovery after a STOP in the middle of a byte or a repeated START, and a sweep of all 256 setting codes through the decoder.

// File: rtl/atten_i2c_target.sv
module atten_i2c_target #(
  parameter int          NCH       = 6,
  parameter int          SLOT_BITS = 3,
  parameter int          ATT_W     = 7,
  parameter int          MAX_DB    = 79,
  parameter int          MUTE_CODE = 10,
  parameter logic [7:0]  BASE_ADDR = 8'h88,
  parameter logic [7:0]  RESET_VAL = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic                   addr_strap,
  output logic                   sda_oe,
  output logic [NCH*ATT_W-1:0]   ch_atten,
  output logic [NCH-1:0]         ch_mute
);
  localparam int PW = SLOT_BITS + 1;
  localparam logic [1:0] S_IDLE = 2'd0, S_ADDR = 2'd1, S_SUB = 2'd2, S_DATA = 2'd3;
  localparam logic [SLOT_BITS-1:0] STEP = 1;

  logic [2:0] scl_sy, sda_sy;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       scl_rise, scl_fall, start_c, stop_c;
  logic [1:0] state;
  logic [3:0] bitcnt;
  logic       in_ack;
  logic [7:0] sr;
  logic [PW-1:0] ptr;
  logic       inc;
  logic       byte_done, wr_en;
  logic [7:0] my_addr;
  logic [7:0] regs [NCH];

  assign scl_s = scl_sy[1];
  assign scl_q = scl_sy[2];
  assign sda_s = sda_sy[1];
  assign sda_q = sda_sy[2];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign my_addr  = BASE_ADDR | {6'b0, addr_strap, 1'b0};
  assign byte_done = scl_fall && (bitcnt == 4'd8) && !in_ack;
  assign wr_en = (state == S_DATA) && byte_done && !ptr[SLOT_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
      sr     <= '0;
      ptr    <= '0;
      inc    <= 1'b0;
    end else if (start_c) begin
      state  <= S_ADDR;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (state != S_IDLE) begin
      if (scl_rise && !in_ack && bitcnt < 4'd8) begin
        sr     <= {sr[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end else if (byte_done) begin
        in_ack <= 1'b1;
        case (state)
          S_ADDR: begin
            if (sr == my_addr) begin
              sda_oe <= 1'b1;
              state  <= S_SUB;
            end else begin
              state  <= S_IDLE;
            end
          end
          S_SUB: begin
            ptr    <= sr[PW-1:0];
            inc    <= sr[PW];
            sda_oe <= 1'b1;
            state  <= S_DATA;
          end
          default: begin
            sda_oe <= 1'b1;
            if (inc) ptr[SLOT_BITS-1:0] <= ptr[SLOT_BITS-1:0] + STEP;
          end
        endcase
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        bitcnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) regs[c] <= RESET_VAL;
    end else if (wr_en) begin
      for (int c = 0; c < NCH; c++)
        if (ptr[SLOT_BITS-1:0] == c[SLOT_BITS-1:0]) regs[c] <= sr;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic mute_g;
    assign mute_g = (regs[g][7:3] >= 5'(MUTE_CODE)) || (32'(regs[g]) > MAX_DB);
    assign ch_mute[g] = mute_g;
    assign ch_atten[g*ATT_W +: ATT_W] = mute_g ? {ATT_W{1'b1}} : regs[g][ATT_W-1:0];
  end
endmodule

// File: rtl/atten_i2c_chk.sv
module atten_i2c_chk #(
  parameter int NCH    = 6,
  parameter int ATT_W  = 7,
  parameter int MAX_DB = 79
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scl_s,
  input logic                 scl_fall,
  input logic                 sda_oe,
  input logic [1:0]           state,
  input logic [NCH*ATT_W-1:0] ch_atten,
  input logic [NCH-1:0]       ch_mute
);
  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_s); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (state == 2'd0) |-> !sda_oe); // R3
  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !scl_fall |=> ($stable(ch_atten) && $stable(ch_mute))); // R11

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_ATTEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) !ch_mute[g] |-> (32'(ch_atten[g*ATT_W +: ATT_W]) <= MAX_DB)); // R8
    AST_MUTE_CODE: assert property (@(posedge clk) disable iff (!rst_n) ch_mute[g] |-> (ch_atten[g*ATT_W +: ATT_W] == {ATT_W{1'b1}})); // R9
  end
endmodule

bind atten_i2c_target atten_i2c_chk #(.NCH(NCH), .ATT_W(ATT_W), .MAX_DB(MAX_DB)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall), .sda_oe(sda_oe),
  .state(state), .ch_atten(ch_atten), .ch_mute(ch_mute)
);

// File: tb/sim_atten_i2c_target.sv
module sim_atten_i2c_target;
  localparam int HP = 10;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_drv = 1'b1, strap = 1'b0;
  logic sda_oe;
  logic [41:0] ch_atten;
  logic [5:0] ch_mute;
  logic sda_bus;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  int expv [6];

  assign sda_bus = sda_drv & ~sda_oe;
  always #10 clk = ~clk;

  atten_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .addr_strap(strap),
    .sda_oe(sda_oe), .ch_atten(ch_atten), .ch_mute(ch_mute)
  );

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int c = 0; c < 6; c++) begin
      int m = (expv[c] >= 80) ? 1 : 0;
      chk(tag, int'(ch_mute[c]), m);
      chk(tag, int'(ch_atten[c*7 +: 7]), m ? 127 : expv[c]);
    end
  endtask

  task automatic i2c_start;
    sda_drv = 1'b1; waitc(HP);
    scl = 1'b1; waitc(HP);
    sda_drv = 1'b0; waitc(HP);
    scl = 1'b0; waitc(2);
  endtask

  task automatic i2c_stop;
    sda_drv = 1'b0; waitc(HP);
    scl = 1'b1; waitc(HP);
    sda_drv = 1'b1; waitc(HP);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; waitc(HP);
    scl = 1'b1; waitc(HP);
    scl = 1'b0; waitc(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input int exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; waitc(HP);
    scl = 1'b1; waitc(HP/2);
    chk(tag, int'(!sda_bus), exp_ack);
    waitc(HP/2);
    scl = 1'b0; waitc(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 6; c++) expv[c] = 255;
    waitc(5);
    chk("R10 oe at reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    waitc(5);
    check_regs("R10 reset mute");
    chk("R10 oe after reset", int'(sda_oe), 0);

    // R5 R8 R9: fixed mode sweep of all codes on channel 4
    i2c_start;
    send_byte(8'h88, 1, "R3 addr 0x88");
    send_byte(8'h03, 1, "R4 sub fixed ch4");
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v), 1, "R7 data ack");
      expv[3] = v;
      check_regs("R8/R9 sweep R5");
    end
    i2c_stop;
    check_regs("R5 after stop");

    // R6: stepping mode from slot 2, wraps 7 -> 0
    i2c_start;
    send_byte(8'h88, 1, "R3 addr");
    send_byte(8'h12, 1, "R4 sub step slot2");
    begin
      int slot = 2;
      for (int k = 0; k < 10; k++) begin
        logic [7:0] d = 8'(10 + 7 * k);
        send_byte(d, 1, "R7 step ack");
        if (slot < 6) expv[slot] = int'(d);
        slot = (slot + 1) % 8;
      end
    end
    i2c_stop;
    check_regs("R6 step wrap");

    // R3: wrong addresses ignored
    i2c_start;
    send_byte(8'h8A, 0, "R3 wrong addr nack");
    send_byte(8'h00, 0, "R3 no ack after mismatch");
    send_byte(8'h05, 0, "R3 no ack after mismatch");
    i2c_stop;
    check_regs("R3 unchanged");
    i2c_start;
    send_byte(8'h89, 0, "R3 read addr nack");
    i2c_stop;

    // R3: strap high moves the address
    strap = 1'b1;
    i2c_start;
    send_byte(8'h88, 0, "R3 strap high rejects 0x88");
    i2c_stop;
    i2c_start;
    send_byte(8'h8A, 1, "R3 strap high accepts 0x8A");
    send_byte(8'hE1, 1, "R4 don't care bits");
    send_byte(8'h2F, 1, "R7 ack");
    i2c_stop;
    expv[1] = 8'h2F;
    check_regs("R4 high bits ignored");
    strap = 1'b0;

    // R4: subaddress bit 3 discards all data
    i2c_start;
    send_byte(8'h88, 1, "R3 addr");
    send_byte(8'h1B, 1, "R4 sub bit3");
    for (int k = 0; k < 9; k++) send_byte(8'h11, 1, "R7 ignored still acked");
    i2c_stop;
    check_regs("R4 bit3 discard");

    // R1: STOP in the middle of a data byte
    i2c_start;
    send_byte(8'h88, 1, "R3 addr");
    send_byte(8'h00, 1, "R4 sub ch1");
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_stop;
    check_regs("R1 mid-byte stop");
    chk("R1 idle oe", int'(sda_oe), 0);

    // R1: repeated START restarts addressing
    i2c_start;
    send_byte(8'h88, 1, "R3 addr");
    send_byte(8'h00, 1, "R4 sub ch1");
    send_byte(8'h05, 1, "R7 ack");
    expv[0] = 5;
    i2c_start;
    send_byte(8'h88, 1, "R1 addr after restart");
    send_byte(8'h05, 1, "R4 sub ch6");
    send_byte(8'h4F, 1, "R7 ack");
    send_byte(8'h50, 1, "R7 ack");
    i2c_stop;
    expv[5] = 8'h50;
    check_regs("R1 repeated start");
    chk("R9 mute at 80", int'(ch_mute[5]), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule